// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block is the bypass-select logic for a five-stage in-order integer pipeline. It takes two producers that may still hold unwritten results: the instruction leaving execute (memory stage) and the instruction in writeback. It checks whether either producer's destination register is one of the source registers of a consumer. There are two consumers: the instruction in execute, which feeds the two ALU operand multiplexers, and a branch in decode, which feeds the two inputs of the equality comparator.

For each of the four consumer inputs the block picks one of three sources: the register-file value, the memory-stage result or the writeback-stage result. It outputs a 2-bit select and the selected data word. The data multiplexers are there so the select logic can be tested in a datapath setting.

The block is purely combinational. Writeback to the register file still happens as usual, because forwarding only supplies values early. Stall generation is handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: The execute-stage operand A select is 2'b10 and its data output equals `mem_res` when `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_a`.
- R2: The execute-stage operand B select follows the same memory-stage rule as R1, using `ex_src_b` instead of `ex_src_a`.
- R3: When the memory stage does not forward to an input, that input's select is 2'b01 and its data is `wb_res` if `wb_wen` is 1, `wb_dst` is nonzero and `wb_dst` equals that input's source register.
- R4: When both stages qualify for the same input, the memory stage wins and the select is 2'b10.
- R5: Register 0 is never forwarded. A source of 0 gives select 2'b00 even when a producer writes register 0 with its write enable set.
- R6: A producer whose write enable is 0 never drives a select, whatever its destination.
- R7: With no qualifying producer, the select is 2'b00 and the data output is the register-file value for that input.
- R8: The decode-stage comparator inputs (`id_src_a`, `id_src_b`) use the same rules and encoding, with outputs on `id_sel_a`/`id_sel_b` and `id_cmp_a`/`id_cmp_b`.
- R9: Each data output always equals the source named by its select: 00 gives the register file, 10 gives `mem_res`, 01 gives `wb_res`.
- R10: The four consumer inputs are resolved independently of each other, so the inputs of one instruction may select different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | REG_AW | Execute-stage first source register |
| ex_src_b | input | REG_AW | Execute-stage second source register |
| id_src_a | input | REG_AW | Decode-stage branch first source register |
| id_src_b | input | REG_AW | Decode-stage branch second source register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_AW | Memory-stage destination register |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | REG_AW | Writeback-stage destination register |
| ex_rf_a | input | DATA_W | Register-file value for execute operand A |
| ex_rf_b | input | DATA_W | Register-file value for execute operand B |
| id_rf_a | input | DATA_W | Register-file value for comparator input A |
| id_rf_b | input | DATA_W | Register-file value for comparator input B |
| mem_res | input | DATA_W | Result held in the memory stage |
| wb_res | input | DATA_W | Result held in the writeback stage |
| ex_sel_a | output | 2 | Select for execute operand A |
| ex_sel_b | output | 2 | Select for execute operand B |
| id_sel_a | output | 2 | Select for comparator input A |
| id_sel_b | output | 2 | Select for comparator input B |
| ex_opnd_a | output | DATA_W | Forwarded execute operand A |
| ex_opnd_b | output | DATA_W | Forwarded execute operand B |
| id_cmp_a | output | DATA_W | Forwarded comparator input A |
| id_cmp_b | output | DATA_W | Forwarded comparator input B |

## Verification
The embedded checks assume that register 0 is hard-wired and that the inputs are settled, known values when they are evaluated. The bench keeps to this by driving every input as a whole vector at once and sampling halfway between clock edges. The sweep draws registers from a small set that includes 0, so that matches, misses and the zero register all occur in every combination of the two write enables. The register-file, memory and writeback data words are kept distinct from one another, so a data output identifies which source it came from.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'b00,
      SEL_WB  = 2'b01,
      SEL_MEM = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int REG_AW     = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic              wen,
   input  logic [REG_AW-1:0] dst,
   input  logic [REG_AW-1:0] src,
   output logic              hit
);
   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   generate
      if (REG_AW < 1) begin : g_bad_aw
         $error("fwd_match: REG_AW must be at least 1");
      end
      if (ZERO_GUARD) begin : g_guard
         assign hit = wen && (dst != ZERO_REG) && (dst == src);
      end else begin : g_plain
         assign hit = wen && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/fwd_sel.sv
module fwd_sel
   import fwd_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic              src_zero_ok,
   input  logic [REG_AW-1:0] src,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              wb_wen,
   input  logic [REG_AW-1:0] wb_dst,
   output fwd_sel_e          sel
);
   logic mem_hit;
   logic wb_hit;

   fwd_match #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_mem (
      .wen(mem_wen), .dst(mem_dst), .src(src), .hit(mem_hit)
   );

   fwd_match #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_wb (
      .wen(wb_wen), .dst(wb_dst), .src(src), .hit(wb_hit)
   );

   // younger producer takes precedence
   always_comb begin
      if (mem_hit)     sel = SEL_MEM;
      else if (wb_hit) sel = SEL_WB;
      else             sel = SEL_RF;
   end

   always_comb begin
      p_sel_onehot_r4: assert ($onehot0(sel))
         else $error("select has more than one bit set");
      p_mem_needs_wen_r6: assert (!(sel == SEL_MEM) || mem_wen)
         else $error("memory source chosen without write enable");
      p_wb_needs_wen_r6: assert (!(sel == SEL_WB) || wb_wen)
         else $error("writeback source chosen without write enable");
      p_zero_src_r5: assert (!(src_zero_ok && src == '0) || sel == SEL_RF)
         else $error("register zero forwarded");
      p_mem_priority_r4: assert (!(mem_wen && mem_dst == src && (!src_zero_ok || src != '0))
                                 || sel == SEL_MEM)
         else $error("memory stage lost priority");
   end
endmodule

// File: rtl/fwd_mux.sv
module fwd_mux
   import fwd_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] rf_val,
   input  logic [DATA_W-1:0] mem_val,
   input  logic [DATA_W-1:0] wb_val,
   output logic [DATA_W-1:0] out
);
   generate
      if (DATA_W < 1) begin : g_bad_dw
         $error("fwd_mux: DATA_W must be at least 1");
      end
   endgenerate

   always_comb begin
      case (sel)
         SEL_MEM: out = mem_val;
         SEL_WB:  out = wb_val;
         default: out = rf_val;
      endcase
   end

   always_comb begin
      p_mux_mem_r9: assert (!(sel == SEL_MEM) || out == mem_val)
         else $error("mux output not memory value");
      p_mux_wb_r9: assert (!(sel == SEL_WB) || out == wb_val)
         else $error("mux output not writeback value");
      p_mux_rf_r7: assert (!(sel == SEL_RF) || out == rf_val)
         else $error("mux output not register-file value");
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter int DATA_W     = 32,
   parameter bit ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] ex_src_a,
   input  logic [REG_AW-1:0] ex_src_b,
   input  logic [REG_AW-1:0] id_src_a,
   input  logic [REG_AW-1:0] id_src_b,
   input  logic              mem_wen,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              wb_wen,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic [DATA_W-1:0] ex_rf_a,
   input  logic [DATA_W-1:0] ex_rf_b,
   input  logic [DATA_W-1:0] id_rf_a,
   input  logic [DATA_W-1:0] id_rf_b,
   input  logic [DATA_W-1:0] mem_res,
   input  logic [DATA_W-1:0] wb_res,
   output logic [1:0]        ex_sel_a,
   output logic [1:0]        ex_sel_b,
   output logic [1:0]        id_sel_a,
   output logic [1:0]        id_sel_b,
   output logic [DATA_W-1:0] ex_opnd_a,
   output logic [DATA_W-1:0] ex_opnd_b,
   output logic [DATA_W-1:0] id_cmp_a,
   output logic [DATA_W-1:0] id_cmp_b
);
   // consumer slots: 0,1 = execute operands, 2,3 = decode comparator
   localparam int NUM_EX   = 2;
   localparam int NUM_ID   = 2;
   localparam int NUM_PATH = NUM_EX + NUM_ID;

   logic [REG_AW-1:0] src_v  [NUM_PATH];
   logic [DATA_W-1:0] rf_v   [NUM_PATH];
   fwd_sel_e          sel_v  [NUM_PATH];
   logic [DATA_W-1:0] data_v [NUM_PATH];

   assign src_v[0] = ex_src_a;
   assign src_v[1] = ex_src_b;
   assign src_v[2] = id_src_a;
   assign src_v[3] = id_src_b;
   assign rf_v[0]  = ex_rf_a;
   assign rf_v[1]  = ex_rf_b;
   assign rf_v[2]  = id_rf_a;
   assign rf_v[3]  = id_rf_b;

   generate
      for (genvar i = 0; i < NUM_PATH; i++) begin : g_path
         fwd_sel #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_sel (
            .src_zero_ok(ZERO_GUARD),
            .src(src_v[i]),
            .mem_wen(mem_wen), .mem_dst(mem_dst),
            .wb_wen(wb_wen),   .wb_dst(wb_dst),
            .sel(sel_v[i])
         );
         fwd_mux #(.DATA_W(DATA_W)) u_mux (
            .sel(sel_v[i]), .rf_val(rf_v[i]),
            .mem_val(mem_res), .wb_val(wb_res),
            .out(data_v[i])
         );
      end
   endgenerate

   assign ex_sel_a  = sel_v[0];
   assign ex_sel_b  = sel_v[1];
   assign id_sel_a  = sel_v[2];
   assign id_sel_b  = sel_v[3];
   assign ex_opnd_a = data_v[0];
   assign ex_opnd_b = data_v[1];
   assign id_cmp_a  = data_v[2];
   assign id_cmp_b  = data_v[3];

   // slots resolve independently: a B-side match never disturbs A
   always_comb begin
      p_slot_indep_r10: assert (!(ex_src_a != ex_src_b && sel_v[0] == SEL_MEM)
                                || sel_v[1] != SEL_MEM)
         else $error("memory result forwarded to non-matching slot");
      p_id_same_rule_r8: assert (!(id_src_a == ex_src_a) || sel_v[2] == sel_v[0])
         else $error("decode and execute rules disagree");
   end
endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam logic [DW-1:0] V_EXA = 32'h1111_1111;
   localparam logic [DW-1:0] V_EXB = 32'h2222_2222;
   localparam logic [DW-1:0] V_IDA = 32'h3333_3333;
   localparam logic [DW-1:0] V_IDB = 32'h4444_4444;
   localparam logic [DW-1:0] V_MEM = 32'h5555_5555;
   localparam logic [DW-1:0] V_WB  = 32'h6666_6666;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [AW-1:0] ex_src_a, ex_src_b, id_src_a, id_src_b, mem_dst, wb_dst;
   logic          mem_wen, wb_wen;
   logic [DW-1:0] ex_rf_a, ex_rf_b, id_rf_a, id_rf_b, mem_res, wb_res;
   logic [1:0]    ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
   logic [DW-1:0] ex_opnd_a, ex_opnd_b, id_cmp_a, id_cmp_b;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   fwd_unit #(.REG_AW(AW), .DATA_W(DW)) dut (
      .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
      .id_src_a(id_src_a), .id_src_b(id_src_b),
      .mem_wen(mem_wen), .mem_dst(mem_dst),
      .wb_wen(wb_wen), .wb_dst(wb_dst),
      .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
      .id_rf_a(id_rf_a), .id_rf_b(id_rf_b),
      .mem_res(mem_res), .wb_res(wb_res),
      .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
      .id_sel_a(id_sel_a), .id_sel_b(id_sel_b),
      .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b),
      .id_cmp_a(id_cmp_a), .id_cmp_b(id_cmp_b)
   );

   // fields: ex_a, ex_b, mem_wen, mem_dst, wb_wen, wb_dst, exp_sel_a, exp_sel_b
   localparam int NV = 10;
   localparam logic [25:0] VEC [NV] = '{
      {5'd2, 5'd3, 1'b1, 5'd2, 1'b0, 5'd0, 2'b10, 2'b00},  // R1
      {5'd4, 5'd7, 1'b1, 5'd7, 1'b0, 5'd0, 2'b00, 2'b10},  // R2
      {5'd9, 5'd1, 1'b0, 5'd9, 1'b1, 5'd9, 2'b01, 2'b00},  // R3, R6
      {5'd6, 5'd6, 1'b1, 5'd6, 1'b1, 5'd6, 2'b10, 2'b10},  // R4
      {5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 2'b00, 2'b00},  // R5
      {5'd8, 5'd8, 1'b0, 5'd8, 1'b0, 5'd8, 2'b00, 2'b00},  // R6
      {5'd1, 5'd2, 1'b1, 5'd3, 1'b1, 5'd4, 2'b00, 2'b00},  // R7
      {5'd5, 5'd11, 1'b1, 5'd5, 1'b1, 5'd11, 2'b10, 2'b01}, // R10
      {5'd31, 5'd30, 1'b1, 5'd30, 1'b1, 5'd31, 2'b01, 2'b10}, // R10
      {5'd12, 5'd0, 1'b1, 5'd0, 1'b1, 5'd12, 2'b01, 2'b00}  // R5, R3
   };

   function automatic logic [1:0] exp_sel(input logic [AW-1:0] s,
                                          input logic mw, input logic [AW-1:0] md,
                                          input logic ww, input logic [AW-1:0] wd);
      if (mw && md != 0 && md == s)      return 2'b10;
      else if (ww && wd != 0 && wd == s) return 2'b01;
      else                               return 2'b00;
   endfunction

   function automatic logic [DW-1:0] exp_val(input logic [1:0] sel, input logic [DW-1:0] rf);
      case (sel)
         2'b10:   return V_MEM;
         2'b01:   return V_WB;
         default: return rf;
      endcase
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [AW-1:0] ea, input logic [AW-1:0] eb,
                        input logic [AW-1:0] ia, input logic [AW-1:0] ib,
                        input logic mw, input logic [AW-1:0] md,
                        input logic ww, input logic [AW-1:0] wd);
      @(posedge clk);
      ex_src_a = ea; ex_src_b = eb; id_src_a = ia; id_src_b = ib;
      mem_wen = mw; mem_dst = md; wb_wen = ww; wb_dst = wd;
      #3;
   endtask

   initial begin
      ex_rf_a = V_EXA; ex_rf_b = V_EXB; id_rf_a = V_IDA; id_rf_b = V_IDB;
      mem_res = V_MEM; wb_res = V_WB;

      // idle state: nothing writing
      apply(5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
      check("R7 idle ex_sel_a", 32'(ex_sel_a), 32'd0);
      check("R7 idle id_cmp_b", id_cmp_b, V_IDB);

      // table walk, same vector also applied to decode side
      for (int v = 0; v < NV; v++) begin
         apply(VEC[v][25:21], VEC[v][20:16], VEC[v][25:21], VEC[v][20:16],
               VEC[v][15], VEC[v][14:10], VEC[v][9], VEC[v][8:4]);
         check("R1 R3 R4 R5 R6 R7 table ex_sel_a", 32'(ex_sel_a), 32'(VEC[v][3:2]));
         check("R2 R3 R4 R5 R6 R7 table ex_sel_b", 32'(ex_sel_b), 32'(VEC[v][1:0]));
         check("R8 table id_sel_a", 32'(id_sel_a), 32'(VEC[v][3:2]));
         check("R8 table id_sel_b", 32'(id_sel_b), 32'(VEC[v][1:0]));
         check("R9 table ex_opnd_a", ex_opnd_a, exp_val(VEC[v][3:2], V_EXA));
         check("R10 table ex_opnd_b", ex_opnd_b, exp_val(VEC[v][1:0], V_EXB));
      end

      // sweep: registers 0..3 everywhere, all enable combinations
      for (int k = 0; k < 1024; k++) begin
         logic [AW-1:0] ea, eb, md, wd;
         logic mw, ww;
         logic [1:0] sa, sb, sc, sd;
         ea = AW'(k[1:0]); eb = AW'(k[3:2]); md = AW'(k[5:4]); wd = AW'(k[7:6]);
         mw = k[8]; ww = k[9];
         apply(ea, eb, eb, ea, mw, md, ww, wd);
         sa = exp_sel(ea, mw, md, ww, wd);
         sb = exp_sel(eb, mw, md, ww, wd);
         sc = exp_sel(eb, mw, md, ww, wd);
         sd = exp_sel(ea, mw, md, ww, wd);
         check("R1 R3 R4 R5 R6 sweep ex_sel_a", 32'(ex_sel_a), 32'(sa));
         check("R2 sweep ex_sel_b", 32'(ex_sel_b), 32'(sb));
         check("R8 sweep id_sel_a", 32'(id_sel_a), 32'(sc));
         check("R8 sweep id_sel_b", 32'(id_sel_b), 32'(sd));
         check("R9 sweep ex_opnd_a", ex_opnd_a, exp_val(sa, V_EXA));
         check("R9 sweep ex_opnd_b", ex_opnd_b, exp_val(sb, V_EXB));
         check("R8 sweep id_cmp_a", id_cmp_a, exp_val(sc, V_IDA));
         check("R8 sweep id_cmp_b", id_cmp_b, exp_val(sd, V_IDB));
      end

      // corner cases on wide register numbers
      apply(5'd31, 5'd16, 5'd31, 5'd16, 1'b1, 5'd31, 1'b1, 5'd16);
      check("R1 top register", ex_opnd_a, V_MEM);
      check("R3 top register b", ex_opnd_b, V_WB);
      check("R8 comparator mem", id_cmp_a, V_MEM);
      apply(5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
      check("R5 zero reg ex", ex_opnd_a, V_EXA);
      check("R5 zero reg id", id_cmp_b, V_IDB);
      apply(5'd17, 5'd17, 5'd17, 5'd17, 1'b0, 5'd17, 1'b1, 5'd17);
      check("R6 mem disabled falls to wb", 32'(ex_sel_b), 32'd1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule